// File: doc/BRIEF.md
# Decrement-and-Branch Processor

This block is a tiny processor that knows exactly one operation. Every instruction names a data byte and two program addresses. The core subtracts one from that byte, stores the result back, and jumps to the first address if the result became zero, or to the second address if it did not. No opcode field exists. A fixed four-step sequencer performs the same flow for every instruction, so the core has no instruction decoder.

Program and data sit in two separate register arrays, and reset clears both. While the core is stopped, a testbench or boot agent loads the program and the data through a simple write port. A pulse on `start` then begins execution at program address 0. An instruction that jumps to its own address on a zero result stops the machine and raises `done`. A combinational debug port reads any data byte at any time.

Top module: `decbr_cpu`

## Requirements
- R1: After reset, `busy`, `done` and `retire` are 0, `pc` is 0, and every data byte reads 0 on the debug port.
- R2: While the core is stopped (idle or halted), `ld_data_we` writes `ld_data_byte` to data address `ld_addr`, and `ld_prog_we` writes `ld_prog_word` to program address `ld_addr`. `dbg_data` always shows the data byte at `dbg_addr`.
- R3: Load strobes that arrive while `busy` is 1 have no effect on either memory.
- R4: Each instruction takes exactly four cycles: fetch, read, write-back and branch. `retire` is 1 only in the branch cycle.
- R5: The write-back stores the addressed byte minus one, modulo 256, so 0 becomes 255.
- R6: The next `pc` is always one of the two encoded targets, never `pc`+1.
- R7: The zero test uses the value after the decrement. A byte holding 1 takes the zero target. A byte holding 0 wraps to 255 and takes the nonzero target.
- R8: When the decremented value is zero and the zero target equals the instruction's own address, `done` rises and `busy` falls. `pc` then stays at that address until the next `start`.
- R9: A `start` pulse while stopped sets `pc` to 0 and clears `done`. `busy` is 1 from the next cycle.
- R10: The instruction word is 18 bits: bits [17:12] hold the data address, bits [11:6] the zero target and bits [5:0] the nonzero target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at address 0 when stopped |
| ld_prog_we | input | 1 | Program write strobe |
| ld_data_we | input | 1 | Data write strobe |
| ld_addr | input | 6 | Load address |
| ld_prog_word | input | 18 | Instruction word to load |
| ld_data_byte | input | 8 | Data byte to load |
| dbg_addr | input | 6 | Debug read address |
| dbg_data | output | 8 | Data byte at `dbg_addr` |
| pc | output | 6 | Program counter |
| busy | output | 1 | Core is executing |
| done | output | 1 | Halt reached |
| retire | output | 1 | Branch cycle of an instruction |

## Verification
On every cycle, the assertions check the step order of the sequencer (fetch, read, write, branch), the choice between the two branch targets, the agreement between the zero flag and the written value, and that a halted core holds its state. Only the bench scenarios can show the results of whole programs. These include counted loops that end in the halt, the wrap from 0 to 255 taking the nonzero path, load strobes ignored in mid-run, and a restart after a halt. The bench shows these through its cycle-by-cycle reference model and through the debug port.

// File: rtl/decbr_pkg.sv
package decbr_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_FETCH, PH_READ, PH_WRITE, PH_BRANCH, PH_HALT
  } phase_e;

  // modular decrement: 0 wraps to all ones
  function automatic logic [DATA_W-1:0] dec_word(input logic [DATA_W-1:0] v);
    return v - {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  // branch selection from the post-decrement zero test
  function automatic logic [ADDR_W-1:0] pick_target(input logic is_zero,
                                                    input logic [ADDR_W-1:0] on_zero,
                                                    input logic [ADDR_W-1:0] on_nonzero);
    return is_zero ? on_zero : on_nonzero;
  endfunction
endpackage

// File: rtl/decbr_prog_mem.sv
module decbr_prog_mem #(
  parameter int AW = 6,
  parameter int IW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [IW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/decbr_data_mem.sv
module decbr_data_mem #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata    = cells[raddr];
  assign dbg_data = cells[dbg_addr];
endmodule

// File: rtl/decbr_seq.sv
module decbr_seq
  import decbr_pkg::*;
#(
  parameter int AW = decbr_pkg::ADDR_W,
  parameter int DW = decbr_pkg::DATA_W,
  localparam int IW = 3 * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] prog_word,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] dat_addr,
  output logic [AW-1:0] tgt_z,
  output logic [AW-1:0] tgt_nz,
  output logic [DW-1:0] wr_data,
  output logic          fetch_en,
  output logic          read_en,
  output logic          wr_en,
  output logic          retire,
  output logic          zero_hit,
  output logic          halt_hit,
  output logic          busy,
  output logic          done
);
  phase_e        phase;
  logic [DW-1:0] val_q;
  logic [AW-1:0] next_pc;
  logic          stopped;

  assign stopped  = (phase == PH_IDLE) || (phase == PH_HALT);
  assign busy     = !stopped;
  assign fetch_en = (phase == PH_FETCH);
  assign read_en  = (phase == PH_READ);
  assign wr_en    = (phase == PH_WRITE);
  assign retire   = (phase == PH_BRANCH);
  assign wr_data  = val_q;
  assign zero_hit = (val_q == '0);
  assign next_pc  = pick_target(zero_hit, tgt_z, tgt_nz);
  assign halt_hit = retire && zero_hit && (tgt_z == pc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      pc       <= '0;
      done     <= 1'b0;
      dat_addr <= '0;
      tgt_z    <= '0;
      tgt_nz   <= '0;
      val_q    <= '0;
    end else begin
      unique case (phase)
        PH_IDLE, PH_HALT: begin
          if (start) begin
            phase <= PH_FETCH;
            pc    <= '0;
            done  <= 1'b0;
          end
        end
        PH_FETCH: begin
          dat_addr <= prog_word[IW-1 -: AW];
          tgt_z    <= prog_word[2*AW-1 -: AW];
          tgt_nz   <= prog_word[AW-1:0];
          phase    <= PH_READ;
        end
        PH_READ: begin
          val_q <= dec_word(rd_data);
          phase <= PH_WRITE;
        end
        PH_WRITE: begin
          phase <= PH_BRANCH;
        end
        PH_BRANCH: begin
          pc <= next_pc;
          if (halt_hit) begin
            phase <= PH_HALT;
            done  <= 1'b1;
          end else begin
            phase <= PH_FETCH;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/decbr_cpu.sv
module decbr_cpu #(
  parameter int AW = decbr_pkg::ADDR_W,
  parameter int DW = decbr_pkg::DATA_W,
  localparam int IW = 3 * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ld_prog_we,
  input  logic          ld_data_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [IW-1:0] ld_prog_word,
  input  logic [DW-1:0] ld_data_byte,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data,
  output logic [AW-1:0] pc,
  output logic          busy,
  output logic          done,
  output logic          retire
);
  logic [IW-1:0] prog_word;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] dat_addr, tgt_z, tgt_nz;
  logic          fetch_en, read_en, wr_en, zero_hit, halt_hit;
  logic          ld_ok, dm_we;
  logic [AW-1:0] dm_waddr;
  logic [DW-1:0] dm_wdata;

  // loader is accepted only while the sequencer is stopped
  assign ld_ok    = !busy;
  assign dm_we    = wr_en || (ld_ok && ld_data_we);
  assign dm_waddr = wr_en ? dat_addr : ld_addr;
  assign dm_wdata = wr_en ? wr_data  : ld_data_byte;

  decbr_prog_mem #(.AW(AW), .IW(IW)) prog_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ld_ok && ld_prog_we),
    .waddr (ld_addr),
    .wdata (ld_prog_word),
    .raddr (pc),
    .rdata (prog_word)
  );

  decbr_data_mem #(.AW(AW), .DW(DW)) data_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (dm_we),
    .waddr    (dm_waddr),
    .wdata    (dm_wdata),
    .raddr    (dat_addr),
    .rdata    (rd_data),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  decbr_seq #(.AW(AW), .DW(DW)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .prog_word (prog_word),
    .rd_data   (rd_data),
    .pc        (pc),
    .dat_addr  (dat_addr),
    .tgt_z     (tgt_z),
    .tgt_nz    (tgt_nz),
    .wr_data   (wr_data),
    .fetch_en  (fetch_en),
    .read_en   (read_en),
    .wr_en     (wr_en),
    .retire    (retire),
    .zero_hit  (zero_hit),
    .halt_hit  (halt_hit),
    .busy      (busy),
    .done      (done)
  );
endmodule

// File: rtl/decbr_cpu_chk.sv
module decbr_cpu_chk #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          fetch_en,
  input logic          read_en,
  input logic          wr_en,
  input logic          retire,
  input logic          zero_hit,
  input logic          halt_hit,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] tgt_z,
  input logic [AW-1:0] tgt_nz,
  input logic [DW-1:0] wr_data
);
  AST_READ_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    read_en |-> $past(fetch_en)); // R4
  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(read_en)); // R4
  AST_BRANCH_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> $past(wr_en)); // R4
  AST_ONE_STEP_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_en, read_en, wr_en, retire})); // R4
  AST_ZERO_FLAG_MATCHES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (zero_hit == ($past(wr_data) == '0))); // R7
  AST_PC_FROM_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (pc == ($past(zero_hit) ? $past(tgt_z) : $past(tgt_nz)))); // R6
  AST_HALT_RAISES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_hit |=> (done && !busy)); // R8
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pc))); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !done && pc == '0)); // R9
endmodule

bind decbr_cpu decbr_cpu_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .fetch_en (fetch_en),
  .read_en  (read_en),
  .wr_en    (wr_en),
  .retire   (retire),
  .zero_hit (zero_hit),
  .halt_hit (halt_hit),
  .busy     (busy),
  .done     (done),
  .pc       (pc),
  .tgt_z    (tgt_z),
  .tgt_nz   (tgt_nz),
  .wr_data  (wr_data)
);

// File: tb/decbr_cpu_tb_top.sv
module decbr_cpu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ld_prog_we = 1'b0;
  logic        ld_data_we = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [17:0] ld_prog_word = '0;
  logic [7:0]  ld_data_byte = '0;
  logic [5:0]  dbg_addr = '0;
  logic [7:0]  dbg_data;
  logic [5:0]  pc;
  logic        busy, done, retire;

  int checks = 0;
  int errors = 0;

  // behavioural reference model
  int m_prog [64];
  int m_data [64];
  int m_pc = 0;
  int m_phase = 0;   // 0 idle, 1 fetch, 2 read, 3 write, 4 branch, 5 halted
  int m_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decbr_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ld_prog_we(ld_prog_we), .ld_data_we(ld_data_we), .ld_addr(ld_addr),
    .ld_prog_word(ld_prog_word), .ld_data_byte(ld_data_byte),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data),
    .pc(pc), .busy(busy), .done(done), .retire(retire)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [17:0] insn(input int a, input int z, input int nz);
    return {a[5:0], z[5:0], nz[5:0]}; // R10 field layout
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin m_prog[i] = 0; m_data[i] = 0; end
      m_pc = 0; m_phase = 0; m_done = 0;
    end else begin
      case (m_phase)
        0, 5: begin
          if (ld_prog_we) m_prog[ld_addr] = ld_prog_word;
          if (ld_data_we) m_data[ld_addr] = ld_data_byte;
          if (start) begin m_phase = 1; m_pc = 0; m_done = 0; end
        end
        1: m_phase = 2;
        2: m_phase = 3;
        3: begin
          int a;
          a = (m_prog[m_pc] >> 12) & 63;
          m_data[a] = (m_data[a] + 255) % 256;
          m_phase = 4;
        end
        default: begin
          int a, z, nz;
          a  = (m_prog[m_pc] >> 12) & 63;
          z  = (m_prog[m_pc] >> 6) & 63;
          nz = m_prog[m_pc] & 63;
          if (m_data[a] == 0 && z == m_pc) begin
            m_done = 1; m_phase = 5;
          end else begin
            m_phase = 1;
          end
          m_pc = (m_data[a] == 0) ? z : nz;
        end
      endcase
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 pc", pc, m_pc);
      check("R4 retire", retire, (m_phase == 4) ? 1 : 0);
      check("R8 done", done, m_done);
      check("R9 busy", busy, (m_phase >= 1 && m_phase <= 4) ? 1 : 0);
      check("R5 dbg_data", dbg_data, m_data[dbg_addr]);
    end
  end

  task automatic load_prog(input int addr, input logic [17:0] w);
    @(negedge clk); ld_addr = addr[5:0]; ld_prog_word = w; ld_prog_we = 1'b1;
    @(negedge clk); ld_prog_we = 1'b0;
  endtask

  task automatic load_data(input int addr, input int v);
    @(negedge clk); ld_addr = addr[5:0]; ld_data_byte = v[7:0]; ld_data_we = 1'b1;
    @(negedge clk); ld_data_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    int n = 0;
    while (!done && n < limit) begin @(negedge clk); n++; end
    if (!done) check("watchdog", 0, 1);
  endtask

  task automatic peek(input string tag, input int addr, input int exp);
    @(negedge clk); dbg_addr = addr[5:0]; #1;
    check(tag, dbg_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 pc", pc, 0);
    check("R1 retire", retire, 0);
    peek("R1 mem0", 0, 0);
    peek("R1 mem63", 63, 0);

    // program 1: countdown loop then self-halt
    load_data(10, 3);
    load_data(12, 1);
    peek("R2 load readback", 10, 3);
    load_prog(0, insn(10, 1, 0));
    load_prog(1, insn(12, 1, 1));
    pulse_start();
    // loader strobe during run must be ignored (R3)
    load_data(10, 99);
    load_prog(1, insn(0, 0, 0));
    wait_done(200);
    @(negedge clk);
    check("R8 halt pc", pc, 1);
    check("R8 busy low", busy, 0);
    peek("R3 counter unchanged by load", 10, 0);
    peek("R7 halt byte", 12, 0);

    // program 2: wrap from zero takes the nonzero path
    load_data(20, 0);
    load_data(21, 1);
    load_prog(0, insn(20, 5, 7));
    load_prog(7, insn(21, 7, 3));
    pulse_start();
    check("R9 pc cleared", pc, 0);
    check("R9 done cleared", done, 0);
    wait_done(200);
    @(negedge clk);
    check("R6 nonzero path halt pc", pc, 7);
    peek("R5 wrap to 255", 20, 255);

    // program 3: zero target taken on value 1, longer chain
    load_data(30, 1);
    load_data(31, 2);
    load_data(32, 1);
    load_prog(0, insn(30, 9, 4));
    load_prog(9, insn(31, 2, 9));
    load_prog(2, insn(32, 2, 2));
    pulse_start();
    wait_done(400);
    @(negedge clk);
    check("R7 zero target chain halt pc", pc, 2);
    peek("R5 chain byte", 31, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule